// File: doc/BRIEF.md
# Multichannel Scan Sequencer with End-of-Scan Flag

This block sets the order in which a converter core samples its inputs. It holds eight configuration bytes, one for each logical channel. A pointer moves through the first one to eight of them. For the logical channel under the pointer, the block presents the selected physical input, the polarity, the gain code and the operating mode to the core. The core reports each finished conversion with a single-cycle done pulse. The sequencer then moves to the next active channel, and after the last active channel it wraps back to the first.

A channel can be set to one of three calibration modes. Such a channel runs that calibration once, and its mode field is then cleared back to plain conversion. Each complete pass over the active channels is a scan. At the end of a scan the block raises an end-of-scan flag, which stays set until it is acknowledged. The flag is withheld in three cases:
- The suppress input is set and calibration took part in the scan.
- After reset or wake-up, the filter-refill count has not yet been reached.
- The block is asleep.

While asleep the block does not scan, and its pointer rests on the first channel. The configuration bytes can still be written in that state.

Top module: `chan_scan_sequencer`

## Requirements
- R1: The number of active channels is `cnt_field` + 1, so 000 gives 1 channel and 111 gives 8. After reset, `cur_lch` is 0, `eos` is 0 and every configuration byte is 0.
- R2: Logical channels 0..3 are read back in `bank_a`, at bits [31:24], [23:16], [15:8] and [7:0] in that order. Logical channels 4..7 take the same positions in `bank_b`.
- R3: Each configuration byte is decoded as follows:
  - Bits 7:5 select the physical input; code n means input n+1.
  - Bit 4 selects bipolar (1) or unipolar (0).
  - Bits 3:2 select the mode: 00 conversion, 01 offset calibration, 10 positive full-scale calibration, 11 negative full-scale calibration.
  - Bits 1:0 select the gain: 00 = x1, 01 = x2, 10 = x4, 11 = x8.
  
  The `sel_*` outputs show the fields of the channel under the pointer.
- R4: Each `conv_done` pulse, when not asleep, moves `cur_lch` on by one in the following cycle. If `cur_lch` is at or beyond the last active channel, it goes to 0 instead. With no pulse, `cur_lch` holds.
- R5: When `conv_done` arrives on a channel whose mode is not 00, that byte's bits 3:2 become 00 in the next cycle and its other bits are kept. If the same byte is written in that same cycle, the write wins.
- R6: `eos` sets in the cycle after the `conv_done` that wraps the pointer, if the scan qualifies. It stays set until `eos_ack`, which clears it one cycle later. A set and an acknowledge in the same cycle leave it set.
- R7: With `suppress_cal` = 1, a scan does not qualify if either condition holds:
  - Any conversion in that scan ran in a calibration mode.
  - Any active channel has a non-00 mode at the scan's end.
  
  Channels beyond the active count are ignored.
- R8: While `sleep` is 1:
  - `cur_lch` is 0 and `eos` is 0.
  - `conv_done` is ignored: the pointer does not advance and no mode is cleared.
  - `hist_clear` is 1 and `scanning` is 0.
  - Writes to the configuration bytes are still accepted.
- R9: After reset or after `sleep` falls, the first scan that can qualify is the 4th complete scan if `lnr_en` = 1, or the 1st if `lnr_en` = 0.
- R10: Changes made in the middle of a scan take effect at once:
  - A write shows on the `sel_*` outputs in the next cycle.
  - If `cnt_field` is lowered below the pointer, the next `conv_done` wraps the pointer to 0 and ends the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_field | input | 3 | Active channel count minus one |
| suppress_cal | input | 1 | Withhold end-of-scan when calibration takes part in the scan |
| lnr_en | input | 1 | Line-noise rejection on; refill needs 4 scans |
| sleep | input | 1 | Stop scanning and park the pointer |
| wr_en | input | 1 | Write strobe for one configuration byte |
| wr_lch | input | 3 | Logical channel to write |
| wr_data | input | 8 | Configuration byte to write |
| conv_done | input | 1 | One-cycle pulse from the core when a conversion finishes |
| eos_ack | input | 1 | Clears the end-of-scan flag |
| cur_lch | output | 3 | Logical channel under the pointer |
| sel_phys | output | 3 | Physical input code of the current channel |
| sel_bipolar | output | 1 | Polarity of the current channel |
| sel_mode | output | 2 | Operating mode of the current channel |
| sel_gain | output | 2 | Gain code of the current channel |
| scanning | output | 1 | High when not asleep |
| hist_clear | output | 1 | Filter history clear, high while asleep |
| eos | output | 1 | End-of-scan flag |
| bank_a | output | 32 | Configuration bytes of logical channels 0..3 |
| bank_b | output | 32 | Configuration bytes of logical channels 4..7 |

## Verification
The main scan is exercised with eight different configuration bytes across all eight channels. Each byte has a distinct physical code, polarity and gain, so a swapped byte lane or a wrong field slice shows up as a wrong value on the `sel_*` outputs at a known pointer position. Further tests vary the count, place calibration modes at the first, middle and last channel of a scan and beyond the active count, and collide a write with a mode clear and an acknowledge with a set. Together these separate the two suppression conditions, the ignoring of inactive channels, and the priority rules. A sleep taken in the middle of a scan, followed by a one-channel scan with line-noise rejection on, pins down the refill count to the exact scan. A count lowered below the pointer tests the early wrap.

// File: rtl/scan_seq_pkg.sv
`timescale 1ns/1ps
package scan_seq_pkg;
  localparam int CFG_W = 8;
  localparam logic [1:0] MODE_CONV = 2'b00;

  // One logical channel's configuration byte; field order is the byte layout.
  typedef struct packed {
    logic [2:0] phys;
    logic       bipolar;
    logic [1:0] mode;
    logic [1:0] gain;
  } chan_cfg_t;

  function automatic logic is_cal(input chan_cfg_t c);
    return c.mode != MODE_CONV;
  endfunction

  function automatic int unsigned refill_need(input logic lnr,
                                              input int unsigned lnr_scans,
                                              input int unsigned plain_scans);
    return lnr ? lnr_scans : plain_scans;
  endfunction
endpackage

// File: rtl/scan_cfg_store.sv
`timescale 1ns/1ps
module scan_cfg_store
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [PTR_W-1:0]             wr_idx,
  input  chan_cfg_t                    wr_data,
  input  logic                         clr_en,
  input  logic [PTR_W-1:0]             clr_idx,
  output chan_cfg_t [NUM_CH-1:0]       cfg_q
);
  chan_cfg_t lane_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    // A write beats the calibration-done mode clear on the same lane.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[g] <= '0;
      end else if (wr_en && wr_idx == PTR_W'(g)) begin
        lane_q[g] <= wr_data;
      end else if (clr_en && clr_idx == PTR_W'(g)) begin
        lane_q[g].mode <= MODE_CONV;
      end
    end
    assign cfg_q[g] = lane_q[g];
  end
endmodule

// File: rtl/scan_pointer.sv
`timescale 1ns/1ps
module scan_pointer #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  logic             conv_done,
  input  logic [PTR_W-1:0] last_idx,
  output logic [PTR_W-1:0] ptr,
  output logic             step,
  output logic             wrap
);
  assign step = conv_done && !sleep;
  // ">=" also catches a count lowered below the pointer mid-scan.
  assign wrap = step && (ptr >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (sleep) begin
      ptr <= '0;
    end else if (step) begin
      ptr <= wrap ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/scan_eos_gen.sv
`timescale 1ns/1ps
module scan_eos_gen
  import scan_seq_pkg::*;
#(
  parameter int LNR_SCANS   = 4,
  parameter int PLAIN_SCANS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  input  logic lnr_en,
  input  logic suppress_cal,
  input  logic step,
  input  logic wrap,
  input  logic cur_is_cal,
  input  logic active_cal,
  input  logic eos_ack,
  output logic eos,
  output logic eos_block,
  output logic refill_ok
);
  localparam int RCNT_W = $clog2(LNR_SCANS + 1);

  logic [RCNT_W-1:0] scans_q;
  logic              cal_seen_q;

  // The scan now ending counts toward the refill.
  assign refill_ok = (32'(scans_q) + 32'd1) >=
                     refill_need(lnr_en, LNR_SCANS, PLAIN_SCANS);
  assign eos_block = suppress_cal && (cal_seen_q || active_cal || cur_is_cal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scans_q <= '0;
    end else if (sleep) begin
      scans_q <= '0;
    end else if (wrap && scans_q < RCNT_W'(LNR_SCANS)) begin
      scans_q <= scans_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_seen_q <= 1'b0;
    end else if (sleep || wrap) begin
      cal_seen_q <= 1'b0;
    end else if (step && cur_is_cal) begin
      cal_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eos <= 1'b0;
    end else if (sleep) begin
      eos <= 1'b0;
    end else if (wrap && refill_ok && !eos_block) begin
      eos <= 1'b1;
    end else if (eos_ack) begin
      eos <= 1'b0;
    end
  end
endmodule

// File: rtl/chan_scan_sequencer.sv
`timescale 1ns/1ps
module chan_scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int  NUM_CH      = 8,
  parameter int  LNR_SCANS   = 4,
  parameter int  PLAIN_SCANS = 1,
  localparam int PTR_W       = $clog2(NUM_CH),
  localparam int BANK_CH     = NUM_CH / 2,
  localparam int BANK_W      = BANK_CH * CFG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  cnt_field,
  input  logic              suppress_cal,
  input  logic              lnr_en,
  input  logic              sleep,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_lch,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              conv_done,
  input  logic              eos_ack,
  output logic [PTR_W-1:0]  cur_lch,
  output logic [2:0]        sel_phys,
  output logic              sel_bipolar,
  output logic [1:0]        sel_mode,
  output logic [1:0]        sel_gain,
  output logic              scanning,
  output logic              hist_clear,
  output logic              eos,
  output logic [BANK_W-1:0] bank_a,
  output logic [BANK_W-1:0] bank_b
);
  chan_cfg_t [NUM_CH-1:0] cfg;
  chan_cfg_t              cur_cfg;
  logic                   step;
  logic                   scan_end;
  logic                   eos_block;
  logic                   refill_ok;
  logic                   clr_en;
  logic [NUM_CH-1:0]      cal_vec;
  logic                   active_cal;

  scan_cfg_store #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_lch),
    .wr_data (chan_cfg_t'(wr_data)),
    .clr_en  (clr_en),
    .clr_idx (cur_lch),
    .cfg_q   (cfg)
  );

  scan_pointer #(.PTR_W(PTR_W)) i_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .conv_done (conv_done),
    .last_idx  (cnt_field),
    .ptr       (cur_lch),
    .step      (step),
    .wrap      (scan_end)
  );

  assign cur_cfg = cfg[cur_lch];
  assign clr_en  = step && is_cal(cur_cfg);

  // Calibration status of active channels only.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_cal
    assign cal_vec[g] = is_cal(cfg[g]) && (PTR_W'(g) <= cnt_field);
  end
  assign active_cal = |cal_vec;

  scan_eos_gen #(.LNR_SCANS(LNR_SCANS), .PLAIN_SCANS(PLAIN_SCANS)) i_eos (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep        (sleep),
    .lnr_en       (lnr_en),
    .suppress_cal (suppress_cal),
    .step         (step),
    .wrap         (scan_end),
    .cur_is_cal   (is_cal(cur_cfg)),
    .active_cal   (active_cal),
    .eos_ack      (eos_ack),
    .eos          (eos),
    .eos_block    (eos_block),
    .refill_ok    (refill_ok)
  );

  // Earlier logical channels sit in the upper byte lanes.
  for (genvar g = 0; g < BANK_CH; g++) begin : g_bank
    assign bank_a[(BANK_CH-1-g)*CFG_W +: CFG_W] = cfg[g];
    assign bank_b[(BANK_CH-1-g)*CFG_W +: CFG_W] = cfg[g+BANK_CH];
  end

  assign sel_phys    = cur_cfg.phys;
  assign sel_bipolar = cur_cfg.bipolar;
  assign sel_mode    = cur_cfg.mode;
  assign sel_gain    = cur_cfg.gain;
  assign scanning    = !sleep;
  assign hist_clear  = sleep;
endmodule

// File: rtl/scan_seq_checker.sv
`timescale 1ns/1ps
module scan_seq_checker #(
  parameter int  NUM_CH  = 8,
  localparam int PTR_W   = $clog2(NUM_CH),
  localparam int BANK_W  = (NUM_CH / 2) * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PTR_W-1:0]  cnt_field,
  input logic              sleep,
  input logic              conv_done,
  input logic              eos_ack,
  input logic              wr_en,
  input logic [PTR_W-1:0]  wr_lch,
  input logic [PTR_W-1:0]  cur_lch,
  input logic [1:0]        sel_mode,
  input logic              eos,
  input logic [BANK_W-1:0] bank_a,
  input logic [BANK_W-1:0] bank_b,
  input logic              scan_end,
  input logic              eos_block
);
  function automatic logic [1:0] mode_at(input logic [2*BANK_W-1:0] f,
                                         input logic [PTR_W-1:0] k);
    int base;
    base = (NUM_CH - 1 - int'(k)) * 8 + 2;
    return f[base +: 2];
  endfunction

  p_wrap_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !sleep && cur_lch >= cnt_field) |=> (cur_lch == '0));

  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !sleep && cur_lch < cnt_field) |=> (cur_lch == $past(cur_lch) + 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !sleep) |=> $stable(cur_lch));

  p_revert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !sleep && sel_mode != 2'b00 && !(wr_en && wr_lch == cur_lch))
      |=> (mode_at({bank_a, bank_b}, $past(cur_lch)) == 2'b00));

  p_eos_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eos) |-> $past(scan_end));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_ack && !scan_end) |=> !eos);

  p_suppress_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_end && eos_block) |=> !$rose(eos));

  p_sleep_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (cur_lch == '0 && !eos));
endmodule

bind chan_scan_sequencer scan_seq_checker #(.NUM_CH(NUM_CH)) i_scan_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_field (cnt_field),
  .sleep     (sleep),
  .conv_done (conv_done),
  .eos_ack   (eos_ack),
  .wr_en     (wr_en),
  .wr_lch    (wr_lch),
  .cur_lch   (cur_lch),
  .sel_mode  (sel_mode),
  .eos       (eos),
  .bank_a    (bank_a),
  .bank_b    (bank_b),
  .scan_end  (scan_end),
  .eos_block (eos_block)
);

// File: tb/test_chan_scan_sequencer.sv
`timescale 1ns/1ps
module test_chan_scan_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cnt_field = '0;
  logic suppress_cal = 1'b0, lnr_en = 1'b0, sleep = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_lch = '0;
  logic [7:0] wr_data = '0;
  logic conv_done = 1'b0, eos_ack = 1'b0;
  logic [2:0] cur_lch, sel_phys;
  logic sel_bipolar, scanning, hist_clear, eos;
  logic [1:0] sel_mode, sel_gain;
  logic [31:0] bank_a, bank_b;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  chan_scan_sequencer i_chan_scan_sequencer (
    .clk(clk), .rst_n(rst_n), .cnt_field(cnt_field), .suppress_cal(suppress_cal),
    .lnr_en(lnr_en), .sleep(sleep), .wr_en(wr_en), .wr_lch(wr_lch),
    .wr_data(wr_data), .conv_done(conv_done), .eos_ack(eos_ack),
    .cur_lch(cur_lch), .sel_phys(sel_phys), .sel_bipolar(sel_bipolar),
    .sel_mode(sel_mode), .sel_gain(sel_gain), .scanning(scanning),
    .hist_clear(hist_clear), .eos(eos), .bank_a(bank_a), .bank_b(bank_b)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step_done();
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic put(input logic [2:0] k, input logic [7:0] d);
    wr_en = 1'b1; wr_lch = k; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ack();
    eos_ack = 1'b1;
    @(negedge clk);
    eos_ack = 1'b0;
  endtask

  // Distinct byte per channel: phys = 7-k, bipolar = k[0], mode 00, gain = k[1:0].
  function automatic logic [7:0] mk(input int k);
    return {3'(7 - k), 1'(k), 2'b00, 2'(k)};
  endfunction

  task automatic t_reset();
    chk("R1", "cur_lch after reset", 32'(cur_lch), 0);
    chk("R1", "eos after reset", 32'(eos), 0);
    chk("R1", "bank_a after reset", bank_a, 0);
    chk("R1", "bank_b after reset", bank_b, 0);
    chk("R8", "scanning/hist_clear awake", 32'({scanning, hist_clear}), 32'b10);
  endtask

  task automatic t_order_decode();
    cnt_field = 3'd7;
    for (int k = 0; k < 8; k++) put(3'(k), mk(k));
    chk("R2", "bank_a lanes", bank_a, {mk(0), mk(1), mk(2), mk(3)});
    chk("R2", "bank_b lanes", bank_b, {mk(4), mk(5), mk(6), mk(7)});
    for (int k = 0; k < 8; k++) begin
      chk("R3", "decoded select", 32'({cur_lch, sel_phys, sel_bipolar, sel_mode, sel_gain}),
          32'({3'(k), mk(k)}));
      chk("R6", "no eos mid-scan", 32'(eos), 0);
      step_done();
    end
    chk("R4", "wrap after 8 channels", 32'(cur_lch), 0);
    chk("R9", "eos after first scan, lnr off", 32'(eos), 1);
    ack();
    chk("R6", "ack clears eos", 32'(eos), 0);
  endtask

  task automatic t_wrap_hold();
    cnt_field = 3'd2;
    repeat (4) @(negedge clk);
    chk("R4", "pointer holds without done", 32'(cur_lch), 0);
    step_done(); chk("R1", "ptr 1 of 3", 32'(cur_lch), 1);
    step_done(); chk("R1", "ptr 2 of 3", 32'(cur_lch), 2);
    step_done(); chk("R1", "wrap after 3", 32'(cur_lch), 0);
    chk("R6", "eos at scan end", 32'(eos), 1);
    step_done(); step_done();
    chk("R6", "eos held until ack", 32'(eos), 1);
    conv_done = 1'b1; eos_ack = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; eos_ack = 1'b0;
    chk("R6", "set beats ack", 32'(eos), 1);
    ack();
    chk("R6", "ack alone clears", 32'(eos), 0);
  endtask

  task automatic t_cal_revert();
    suppress_cal = 1'b0;
    put(3'd1, 8'h56);
    step_done();
    chk("R3", "offset cal mode shown", 32'(sel_mode), 32'b01);
    step_done();
    chk("R5", "mode cleared, rest kept", 32'(bank_a[23:16]), 32'h52);
    step_done();
    chk("R7", "cal scan not suppressed when off", 32'(eos), 1);
    ack();
    put(3'd2, 8'h6C);
    step_done(); step_done();
    chk("R3", "negative cal mode shown", 32'(sel_mode), 32'b11);
    conv_done = 1'b1; wr_en = 1'b1; wr_lch = 3'd2; wr_data = 8'h6D;
    @(negedge clk);
    conv_done = 1'b0; wr_en = 1'b0;
    chk("R5", "write beats clear", 32'(bank_a[15:8]), 32'h6D);
    ack();
  endtask

  task automatic t_suppress();
    suppress_cal = 1'b1;
    repeat (3) step_done();
    chk("R7", "suppressed, last channel cal", 32'(eos), 0);
    chk("R5", "ch2 cleared", 32'(bank_a[15:8]), 32'h61);
    repeat (3) step_done();
    chk("R7", "clean scan gives eos", 32'(eos), 1);
    ack();
    put(3'd0, 8'hE4);
    repeat (3) step_done();
    chk("R5", "ch0 cleared", 32'(bank_a[31:24]), 32'hE0);
    chk("R7", "suppressed, cal earlier in scan", 32'(eos), 0);
    repeat (3) step_done();
    chk("R7", "eos back after clean scan", 32'(eos), 1);
    ack();
    put(3'd5, 8'hAC);
    repeat (3) step_done();
    chk("R7", "inactive channel cal ignored", 32'(eos), 1);
    chk("R7", "inactive cal byte untouched", 32'(bank_b[23:16]), 32'hAC);
  endtask

  task automatic t_sleep_refill();
    step_done();
    chk("R4", "ptr 1 before sleep", 32'(cur_lch), 1);
    sleep = 1'b1;
    @(negedge clk);
    chk("R8", "ptr parked", 32'(cur_lch), 0);
    chk("R8", "eos cleared", 32'(eos), 0);
    chk("R8", "scanning/hist_clear asleep", 32'({scanning, hist_clear}), 32'b01);
    put(3'd0, 8'hE5);
    chk("R8", "write while asleep", 32'(bank_a[31:24]), 32'hE5);
    step_done();
    chk("R8", "done ignored: ptr", 32'(cur_lch), 0);
    chk("R8", "done ignored: no clear", 32'(bank_a[31:24]), 32'hE5);
    chk("R8", "config kept", 32'(bank_b[23:16]), 32'hAC);
    suppress_cal = 1'b0; lnr_en = 1'b1; cnt_field = 3'd0;
    sleep = 1'b0;
    @(negedge clk);
    for (int s = 1; s <= 4; s++) begin
      step_done();
      chk("R1", "one channel wraps", 32'(cur_lch), 0);
      chk("R9", "refill with lnr on", 32'(eos), (s == 4) ? 1 : 0);
    end
    chk("R5", "cal after wake cleared", 32'(bank_a[31:24]), 32'hE1);
  endtask

  task automatic t_midscan();
    ack();
    lnr_en = 1'b0; cnt_field = 3'd7;
    repeat (5) step_done();
    chk("R10", "ptr at 5", 32'(cur_lch), 5);
    chk("R10", "phys before write", 32'(sel_phys), 5);
    put(3'd5, 8'h20);
    chk("R10", "write seen next cycle", 32'(sel_phys), 1);
    cnt_field = 3'd2;
    step_done();
    chk("R10", "shrunk count wraps", 32'(cur_lch), 0);
    chk("R10", "early wrap ends scan", 32'(eos), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order_decode();
    t_wrap_hold();
    t_cal_revert();
    t_suppress();
    t_sleep_refill();
    t_midscan();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule